// File: doc/BRIEF.md
# Link Speed and Bandwidth Notifier

This block decides at which rate and lane width a serial link runs and tells software when the bandwidth changes. It compares the rates the far end advertises with the rates the local port can run, caps the result with a software ceiling, and hands the chosen rate and width to an abstract physical layer through a retrain strobe. The physical layer acknowledges the strobe once the link is up again. Only at that point do the current-rate and current-width outputs move.

A retrain can start for one of three reasons. Software asks for it, the link degrades and must step down to stay reliable, or power management asks for a downshift or a restore. The last reason is autonomous, and two disable bits can block it separately for rate and for width. A reliability step-down ignores those bits. Reliability retrains and autonomous retrains each set their own sticky status bit when they complete. Each bit has its own interrupt enable and a write-one-to-clear input, and a single interrupt line merges the enabled bits.

Top module: `link_bw_notifier`

## Requirements
- R1: After reset the current rate is 1, the current width code is 0, the retrain strobe is low, both status bits are 0 and the interrupt is low.
- R2: A software train request picks the highest rate whose bit is set in both supported-rate vectors (bit 0 = rate 1, the base rate; bit 1 = rate 2, double rate), or rate 1 if no bit is shared. This rate is limited to the target field, where a target of 0 counts as 1. The width is the max-width code (lane count is 2 to the power of the code).
- R3: The retrain strobe stays high with stable rate and width until the acknowledge. The current rate and width take the new values at the acknowledge edge and hold at all other times.
- R4: A degrade request lowers the rate by one step, or if the rate is already 1 it decrements the width code. It does this even when both disable bits are set. It is ignored at rate 1 with width code 0.
- R5: Completion of a degrade retrain sets the management status bit and leaves the autonomous status bit unchanged.
- R6: A power-down request moves the rate to 1 unless rate changes are disabled, and the width code to 0 unless width changes are disabled. If neither changes, the request is ignored.
- R7: A power-up request moves the rate to the value R2 gives and the width to the max-width code, under the same two disable bits. If neither changes, the request is ignored.
- R8: Completion of a power-down or power-up retrain sets the autonomous status bit. A software train sets neither status bit.
- R9: A one on a clear input clears its status bit. If a set happens in the same cycle, the set wins.
- R10: The interrupt is high exactly when some status bit is 1 and its enable is 1.
- R11: Requests are taken only while no retrain is outstanding, and requests that arrive during one are dropped. When several arrive together, degrade has priority over train, train over power-down, and power-down over power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| partner_rates | input | SPD_N | Rates the far end supports, bit i = rate i+1 |
| local_rates | input | SPD_N | Rates this port supports |
| target_rate | input | SPD_W | Software rate ceiling |
| max_width | input | WID_W | Widest width code the link can use |
| auto_rate_dis | input | 1 | Blocks autonomous rate changes |
| auto_width_dis | input | 1 | Blocks autonomous width changes |
| train_req | input | 1 | Software retrain request |
| degrade_req | input | 1 | Reliability step-down request |
| pm_down_req | input | 1 | Power-management downshift request |
| pm_up_req | input | 1 | Power-management restore request |
| phy_ack | input | 1 | Physical layer finished the retrain |
| ie_auto | input | 1 | Interrupt enable, autonomous status |
| ie_mgmt | input | 1 | Interrupt enable, management status |
| clr_auto | input | 1 | Write-one-to-clear, autonomous status |
| clr_mgmt | input | 1 | Write-one-to-clear, management status |
| retrain_req | output | 1 | Retrain strobe to physical layer |
| retrain_rate | output | SPD_W | Rate for the retrain |
| retrain_width | output | WID_W | Width code for the retrain |
| cur_rate | output | SPD_W | Current link rate |
| cur_width | output | WID_W | Current width code |
| sts_auto | output | 1 | Sticky autonomous bandwidth status |
| sts_mgmt | output | 1 | Sticky management bandwidth status |
| irq | output | 1 | Interrupt |

## Verification
Two things can land in one cycle. Software can write the clear for a status bit in the same cycle that a retrain completes and sets that bit. The bench forces this by asserting the clear together with the acknowledge of a power-up retrain, and expects the bit to read 1 afterwards. A degrade and a train request can also arrive in the same cycle. For that case the bench checks that the strobe carries the degraded rate, that the management status bit is set, and that a train pulse sent while the retrain is outstanding leaves no second strobe.

// File: rtl/lbn_pkg.sv
package lbn_pkg;
    typedef enum logic [1:0] {
        CAUSE_TRAIN = 2'd0,
        CAUSE_AUTO  = 2'd1,
        CAUSE_MGMT  = 2'd2
    } lbn_cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } lbn_state_e;
endpackage

// File: rtl/lbn_rate_pick.sv
module lbn_rate_pick #(
    parameter int SPD_N = 2,
    parameter int SPD_W = $clog2(SPD_N + 1)
) (
    input  logic [SPD_N-1:0] partner_rates,
    input  logic [SPD_N-1:0] local_rates,
    input  logic [SPD_W-1:0] target_rate,
    output logic [SPD_W-1:0] capped_rate
);
    logic [SPD_W-1:0] common_max;
    logic [SPD_W-1:0] ceiling;

    always_comb begin
        common_max = SPD_W'(1);
        for (int i = 0; i < SPD_N; i++) begin
            if (partner_rates[i] && local_rates[i]) begin
                common_max = SPD_W'(i + 1);
            end
        end
        ceiling     = (target_rate == '0) ? SPD_W'(1) : target_rate;
        capped_rate = (common_max < ceiling) ? common_max : ceiling;
    end
endmodule

// File: rtl/lbn_retrain_ctl.sv
module lbn_retrain_ctl
    import lbn_pkg::*;
#(
    parameter int SPD_W = 2,
    parameter int WID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] capped_rate,
    input  logic [WID_W-1:0] max_width,
    input  logic             auto_rate_dis,
    input  logic             auto_width_dis,
    input  logic             train_req,
    input  logic             degrade_req,
    input  logic             pm_down_req,
    input  logic             pm_up_req,
    input  logic             phy_ack,
    output logic             retrain_req,
    output logic [SPD_W-1:0] retrain_rate,
    output logic [WID_W-1:0] retrain_width,
    output logic [SPD_W-1:0] cur_rate,
    output logic [WID_W-1:0] cur_width,
    output logic             evt_auto,
    output logic             evt_mgmt
);
    typedef struct packed {
        lbn_state_e       st;
        lbn_cause_e       cause;
        logic [SPD_W-1:0] pend_rate;
        logic [WID_W-1:0] pend_width;
        logic [SPD_W-1:0] rate;
        logic [WID_W-1:0] width;
    } ctl_t;

    ctl_t q, d;

    logic [SPD_W-1:0] dg_rate, dn_rate, up_rate;
    logic [WID_W-1:0] dg_width, dn_width, up_width;
    logic             dg_ok, dn_ok, up_ok;

    always_comb begin
        dg_ok = (q.rate > SPD_W'(1)) || (q.width != '0);
        if (q.rate > SPD_W'(1)) begin
            dg_rate  = q.rate - SPD_W'(1);
            dg_width = q.width;
        end else begin
            dg_rate  = q.rate;
            dg_width = (q.width != '0) ? (q.width - WID_W'(1)) : q.width;
        end

        dn_rate  = auto_rate_dis  ? q.rate  : SPD_W'(1);
        dn_width = auto_width_dis ? q.width : '0;
        dn_ok    = (dn_rate != q.rate) || (dn_width != q.width);

        up_rate  = auto_rate_dis  ? q.rate  : capped_rate;
        up_width = auto_width_dis ? q.width : max_width;
        up_ok    = (up_rate != q.rate) || (up_width != q.width);

        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (degrade_req && dg_ok) begin
                    d.st         = ST_WAIT;
                    d.cause      = CAUSE_MGMT;
                    d.pend_rate  = dg_rate;
                    d.pend_width = dg_width;
                end else if (train_req) begin
                    d.st         = ST_WAIT;
                    d.cause      = CAUSE_TRAIN;
                    d.pend_rate  = capped_rate;
                    d.pend_width = max_width;
                end else if (pm_down_req && dn_ok) begin
                    d.st         = ST_WAIT;
                    d.cause      = CAUSE_AUTO;
                    d.pend_rate  = dn_rate;
                    d.pend_width = dn_width;
                end else if (pm_up_req && up_ok) begin
                    d.st         = ST_WAIT;
                    d.cause      = CAUSE_AUTO;
                    d.pend_rate  = up_rate;
                    d.pend_width = up_width;
                end
            end
            ST_WAIT: begin
                if (phy_ack) begin
                    d.st    = ST_IDLE;
                    d.rate  = q.pend_rate;
                    d.width = q.pend_width;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st         <= ST_IDLE;
            q.cause      <= CAUSE_TRAIN;
            q.pend_rate  <= SPD_W'(1);
            q.pend_width <= '0;
            q.rate       <= SPD_W'(1);
            q.width      <= '0;
        end else begin
            q <= d;
        end
    end

    assign retrain_req   = (q.st == ST_WAIT);
    assign retrain_rate  = q.pend_rate;
    assign retrain_width = q.pend_width;
    assign cur_rate      = q.rate;
    assign cur_width     = q.width;
    assign evt_auto      = retrain_req && phy_ack && (q.cause == CAUSE_AUTO);
    assign evt_mgmt      = retrain_req && phy_ack && (q.cause == CAUSE_MGMT);
endmodule

// File: rtl/lbn_status.sv
module lbn_status #(
    parameter int NSTS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTS-1:0] set_evt,
    input  logic [NSTS-1:0] clr_w1,
    input  logic [NSTS-1:0] int_en,
    output logic [NSTS-1:0] sts,
    output logic            irq
);
    logic [NSTS-1:0] sts_d, sts_q;

    always_comb begin
        for (int i = 0; i < NSTS; i++) begin
            sts_d[i] = set_evt[i] | (sts_q[i] & ~clr_w1[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts = sts_q;
    assign irq = |(sts_q & int_en);
endmodule

// File: rtl/link_bw_notifier.sv
module link_bw_notifier #(
    parameter int SPD_N = 2,
    parameter int WID_W = 3,
    localparam int SPD_W = $clog2(SPD_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_N-1:0] partner_rates,
    input  logic [SPD_N-1:0] local_rates,
    input  logic [SPD_W-1:0] target_rate,
    input  logic [WID_W-1:0] max_width,
    input  logic             auto_rate_dis,
    input  logic             auto_width_dis,
    input  logic             train_req,
    input  logic             degrade_req,
    input  logic             pm_down_req,
    input  logic             pm_up_req,
    input  logic             phy_ack,
    input  logic             ie_auto,
    input  logic             ie_mgmt,
    input  logic             clr_auto,
    input  logic             clr_mgmt,
    output logic             retrain_req,
    output logic [SPD_W-1:0] retrain_rate,
    output logic [WID_W-1:0] retrain_width,
    output logic [SPD_W-1:0] cur_rate,
    output logic [WID_W-1:0] cur_width,
    output logic             sts_auto,
    output logic             sts_mgmt,
    output logic             irq
);
    logic [SPD_W-1:0] capped_rate;
    logic             evt_auto, evt_mgmt;
    logic [1:0]       sts_vec;

    lbn_rate_pick #(.SPD_N(SPD_N), .SPD_W(SPD_W)) u_pick (
        .partner_rates (partner_rates),
        .local_rates   (local_rates),
        .target_rate   (target_rate),
        .capped_rate   (capped_rate)
    );

    lbn_retrain_ctl #(.SPD_W(SPD_W), .WID_W(WID_W)) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .capped_rate    (capped_rate),
        .max_width      (max_width),
        .auto_rate_dis  (auto_rate_dis),
        .auto_width_dis (auto_width_dis),
        .train_req      (train_req),
        .degrade_req    (degrade_req),
        .pm_down_req    (pm_down_req),
        .pm_up_req      (pm_up_req),
        .phy_ack        (phy_ack),
        .retrain_req    (retrain_req),
        .retrain_rate   (retrain_rate),
        .retrain_width  (retrain_width),
        .cur_rate       (cur_rate),
        .cur_width      (cur_width),
        .evt_auto       (evt_auto),
        .evt_mgmt       (evt_mgmt)
    );

    lbn_status #(.NSTS(2)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt ({evt_mgmt, evt_auto}),
        .clr_w1  ({clr_mgmt, clr_auto}),
        .int_en  ({ie_mgmt, ie_auto}),
        .sts     (sts_vec),
        .irq     (irq)
    );

    assign sts_auto = sts_vec[0];
    assign sts_mgmt = sts_vec[1];
endmodule

// File: rtl/lbn_checker.sv
module lbn_checker #(
    parameter int SPD_N = 2,
    parameter int WID_W = 3,
    parameter int SPD_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phy_ack,
    input logic             ie_auto,
    input logic             ie_mgmt,
    input logic             clr_auto,
    input logic             clr_mgmt,
    input logic             retrain_req,
    input logic [SPD_W-1:0] retrain_rate,
    input logic [WID_W-1:0] retrain_width,
    input logic [SPD_W-1:0] cur_rate,
    input logic [WID_W-1:0] cur_width,
    input logic             sts_auto,
    input logic             sts_mgmt,
    input logic             irq
);
    // R3: strobe held with stable fields until acknowledged
    assert_hold_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (retrain_req && !phy_ack) |=> (retrain_req && $stable(retrain_rate) && $stable(retrain_width)));

    // R3: current values move only on an acknowledged strobe
    assert_cur_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(retrain_req && phy_ack) |=> ($stable(cur_rate) && $stable(cur_width)));

    // R2: current rate stays in the legal code range
    assert_rate_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_rate >= SPD_W'(1)) && (cur_rate <= SPD_W'(SPD_N)));

    // R8: autonomous status rises only after an acknowledge
    assert_auto_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_auto) |-> $past(retrain_req && phy_ack));

    // R5: management status rises only after an acknowledge
    assert_mgmt_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_mgmt) |-> $past(retrain_req && phy_ack));

    // R9: a clear with no completion in the same cycle clears the bit
    assert_clr_auto_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_auto && !(retrain_req && phy_ack)) |=> !sts_auto);

    assert_clr_mgmt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mgmt && !(retrain_req && phy_ack)) |=> !sts_mgmt);

    // R10: no interrupt when both enables are off
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_auto && !ie_mgmt) |-> !irq);
endmodule

bind link_bw_notifier lbn_checker #(.SPD_N(SPD_N), .WID_W(WID_W), .SPD_W(SPD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .phy_ack       (phy_ack),
    .ie_auto       (ie_auto),
    .ie_mgmt       (ie_mgmt),
    .clr_auto      (clr_auto),
    .clr_mgmt      (clr_mgmt),
    .retrain_req   (retrain_req),
    .retrain_rate  (retrain_rate),
    .retrain_width (retrain_width),
    .cur_rate      (cur_rate),
    .cur_width     (cur_width),
    .sts_auto      (sts_auto),
    .sts_mgmt      (sts_mgmt),
    .irq           (irq)
);

// File: tb/link_bw_notifier_tb.sv
module link_bw_notifier_tb;
    localparam int SPD_N = 2;
    localparam int WID_W = 3;
    localparam int SPD_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SPD_N-1:0] partner_rates = '0, local_rates = '0;
    logic [SPD_W-1:0] target_rate = '0;
    logic [WID_W-1:0] max_width = '0;
    logic auto_rate_dis = 0, auto_width_dis = 0;
    logic train_req = 0, degrade_req = 0, pm_down_req = 0, pm_up_req = 0;
    logic phy_ack = 0, ie_auto = 0, ie_mgmt = 0, clr_auto = 0, clr_mgmt = 0;
    logic retrain_req;
    logic [SPD_W-1:0] retrain_rate, cur_rate;
    logic [WID_W-1:0] retrain_width, cur_width;
    logic sts_auto, sts_mgmt, irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    link_bw_notifier #(.SPD_N(SPD_N), .WID_W(WID_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .partner_rates(partner_rates), .local_rates(local_rates),
        .target_rate(target_rate), .max_width(max_width),
        .auto_rate_dis(auto_rate_dis), .auto_width_dis(auto_width_dis),
        .train_req(train_req), .degrade_req(degrade_req),
        .pm_down_req(pm_down_req), .pm_up_req(pm_up_req),
        .phy_ack(phy_ack), .ie_auto(ie_auto), .ie_mgmt(ie_mgmt),
        .clr_auto(clr_auto), .clr_mgmt(clr_mgmt),
        .retrain_req(retrain_req), .retrain_rate(retrain_rate),
        .retrain_width(retrain_width), .cur_rate(cur_rate),
        .cur_width(cur_width), .sts_auto(sts_auto), .sts_mgmt(sts_mgmt),
        .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one-cycle request pulse; returns at the negedge after the sampling edge
    task automatic send_req(input bit dg, input bit tr, input bit pd, input bit pu);
        @(negedge clk);
        degrade_req = dg; train_req = tr; pm_down_req = pd; pm_up_req = pu;
        @(negedge clk);
        degrade_req = 0; train_req = 0; pm_down_req = 0; pm_up_req = 0;
    endtask

    // check strobe contents, acknowledge, then check the current values
    task automatic finish_retrain(input string tag, input int er, input int ew, input bit clr_a);
        check({tag, " strobe"}, int'(retrain_req), 1);
        check({tag, " strobe rate"}, int'(retrain_rate), er);
        check({tag, " strobe width"}, int'(retrain_width), ew);
        phy_ack = 1; clr_auto = clr_a;
        @(negedge clk);
        phy_ack = 0; clr_auto = 0;
        check({tag, " strobe drop"}, int'(retrain_req), 0);
        check({tag, " cur rate"}, int'(cur_rate), er);
        check({tag, " cur width"}, int'(cur_width), ew);
    endtask

    task automatic expect_idle(input string tag);
        repeat (2) @(negedge clk);
        check({tag, " no strobe"}, int'(retrain_req), 0);
    endtask

    task automatic clear_all();
        @(negedge clk); clr_auto = 1; clr_mgmt = 1;
        @(negedge clk); clr_auto = 0; clr_mgmt = 0;
    endtask

    task automatic t_reset();
        check("R1 rate", int'(cur_rate), 1);
        check("R1 width", int'(cur_width), 0);
        check("R1 strobe", int'(retrain_req), 0);
        check("R1 sts_auto", int'(sts_auto), 0);
        check("R1 sts_mgmt", int'(sts_mgmt), 0);
        check("R1 irq", int'(irq), 0);
    endtask

    task automatic t_train();
        partner_rates = 2'b11; local_rates = 2'b11; target_rate = 2; max_width = 4;
        send_req(0, 1, 0, 0);
        repeat (2) @(negedge clk);
        check("R3 held", int'(retrain_req), 1);
        check("R3 cur unchanged", int'(cur_rate), 1);
        finish_retrain("R2 full", 2, 4, 0);
        check("R8 train no auto", int'(sts_auto), 0);
        check("R8 train no mgmt", int'(sts_mgmt), 0);
        target_rate = 1;
        send_req(0, 1, 0, 0); finish_retrain("R2 cap1", 1, 4, 0);
        target_rate = 0;
        send_req(0, 1, 0, 0); finish_retrain("R2 cap0", 1, 4, 0);
        target_rate = 2; partner_rates = 2'b01;
        send_req(0, 1, 0, 0); finish_retrain("R2 partner base", 1, 4, 0);
        partner_rates = 2'b11;
        send_req(0, 1, 0, 0); finish_retrain("R2 restore", 2, 4, 0);
    endtask

    task automatic t_degrade();
        ie_mgmt = 1;
        send_req(1, 0, 0, 0); finish_retrain("R4 rate step", 1, 4, 0);
        check("R5 mgmt set", int'(sts_mgmt), 1);
        check("R5 auto untouched", int'(sts_auto), 0);
        check("R10 irq mgmt", int'(irq), 1);
        ie_mgmt = 0; @(negedge clk);
        check("R10 irq masked", int'(irq), 0);
        ie_mgmt = 1;
        auto_rate_dis = 1; auto_width_dis = 1;
        send_req(1, 0, 0, 0); finish_retrain("R4 width step dis", 1, 3, 0);
        auto_rate_dis = 0; auto_width_dis = 0;
        @(negedge clk); clr_mgmt = 1; @(negedge clk); clr_mgmt = 0;
        check("R9 clear mgmt", int'(sts_mgmt), 0);
        check("R10 irq after clear", int'(irq), 0);
        ie_mgmt = 0;
    endtask

    task automatic t_power();
        send_req(0, 0, 0, 1); finish_retrain("R7 up", 2, 4, 0);
        check("R8 auto set", int'(sts_auto), 1);
        check("R10 irq disabled", int'(irq), 0);
        clear_all();
        check("R9 clear auto", int'(sts_auto), 0);
        auto_rate_dis = 1;
        send_req(0, 0, 1, 0); finish_retrain("R6 down rate dis", 2, 0, 0);
        auto_width_dis = 1;
        clear_all();
        send_req(0, 0, 1, 0); expect_idle("R6 down all dis");
        check("R6 no status", int'(sts_auto), 0);
        auto_rate_dis = 0;
        send_req(0, 0, 0, 1); expect_idle("R7 up no change");
        auto_width_dis = 0;
        send_req(0, 0, 0, 1); finish_retrain("R7 width up", 2, 4, 0);
        auto_width_dis = 1;
        send_req(0, 0, 1, 0); finish_retrain("R6 down width dis", 1, 4, 0);
        auto_width_dis = 0;
    endtask

    task automatic t_collision();
        send_req(0, 0, 0, 1);
        finish_retrain("R9 set vs clear", 2, 4, 1);
        check("R9 set wins", int'(sts_auto), 1);
        ie_auto = 1; @(negedge clk);
        check("R10 irq auto", int'(irq), 1);
        ie_auto = 0;
        clear_all();
    endtask

    task automatic t_priority();
        send_req(1, 1, 1, 1);
        check("R11 degrade first rate", int'(retrain_rate), 1);
        send_req(0, 1, 0, 0);
        finish_retrain("R11 degrade wins", 1, 4, 0);
        check("R11 mgmt set", int'(sts_mgmt), 1);
        check("R11 auto clear", int'(sts_auto), 0);
        expect_idle("R11 busy train dropped");
        clear_all();
    endtask

    task automatic t_floor();
        target_rate = 1; max_width = 0;
        send_req(0, 1, 0, 0); finish_retrain("R2 narrow", 1, 0, 0);
        send_req(1, 0, 0, 0); expect_idle("R4 floor ignored");
        check("R4 floor no status", int'(sts_mgmt), 0);
        check("R4 floor rate", int'(cur_rate), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_train();
        t_degrade();
        t_power();
        t_collision();
        t_priority();
        t_floor();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule